// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external pin timing for one machine cycle of a small 8-bit processor with a 16-bit address space (65536 byte locations). A requester presents a cycle kind, an address and, for writes, a data byte. The block then steps through the T-states of that cycle. It drives the upper address byte on its own lines. It places the lower address byte and the data on one shared set of lines, and an address strobe marks when those lines hold address.

Alongside the bus lines it drives three status lines and active-low read and write strobes. At the end of the cycle it returns the byte read and a one-cycle completion pulse. An opcode fetch runs for four T-states. Memory and I/O reads and writes run for three.

The shared lines appear as a separate output byte plus an output-enable, and the incoming byte arrives on its own input. The pad level merges these into one tri-state bus, and a low enable means the lines are released (high impedance).

Top module: `bus_seq_top`

## Requirements
- R1: A request is taken at a rising edge only when `busy` is low, `req_valid` is high and `req_kind` is a legal code: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 and any request seen while `busy` is high are ignored and cause no pin activity. A request held during the `done` cycle starts the next machine cycle on the following clock.
- R2: After acceptance, `busy` is high for exactly 4 clocks for an opcode fetch and 3 clocks for every other kind. Each clock is one T-state, starting with T1 in the clock after the accepting edge.
- R3: `ale` is high only in T1. In T1, `ad_oe` is 1 and `ad_out` carries address bits 7:0. `addr_hi` carries address bits 15:8 in every T-state and is 0 when idle.
- R4: The status lines {`io_m`,`s1`,`s0`} hold, through all T-states, 011 for opcode fetch, 010 for memory read, 001 for memory write, 110 for I/O read and 101 for I/O write. They are 000 when idle.
- R5: `rd_n` is low in T2 and T3 of opcode fetch, memory read and I/O read, and high at all other times. `wr_n` is low in T2 and T3 of memory write and I/O write, and high at all other times. The two are never low together.
- R6: In T2 and T3 of a write, `ad_oe` is 1 and `ad_out` equals the request's write byte. In T2 onward of any read kind, `ad_oe` is 0.
- R7: `rdata` takes the value on `ad_in` during T3 of a fetch or read and holds it until the next such cycle reaches T3. Writes leave it unchanged.
- R8: `done` is high for exactly one clock: the clock after the last T-state, in which `busy` is already low. T4 of an opcode fetch has both strobes high and `ad_oe` at 0.
- R9: While `rst_n` is low, `busy`, `done`, `ale` and `ad_oe` are 0, `rd_n` and `wr_n` are 1, the status lines are 000 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code (see R1) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A machine cycle is in its T-states |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured in T3 of the last read or fetch |
| ale | output | 1 | Address strobe for the shared lines |
| io_m | output | 1 | Status: 1 for I/O space, 0 for memory |
| s1 | output | 1 | Status line 1 |
| s0 | output | 1 | Status line 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| addr_hi | output | 8 | Address bits 15:8 |
| ad_out | output | 8 | Byte driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Byte present on the shared lines |

## Verification
The bench sends each of the five kinds with different addresses and data, including the all-zero and all-one addresses. A design that gave an opcode fetch only three T-states would drop `done` one clock early, and one that mixed up the status table would show the wrong triple. The bench changes `ad_in` on every clock so that a capture in T2 or T4 gives the wrong `rdata`. It also fires requests while busy and with illegal codes, which a design with a loose acceptance test would start or restart. Finally it holds a request across the `done` clock to check that machine cycles follow each other with one idle clock between them, and that the shared lines are released through T4 of a fetch.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int FETCH_LEN = 4;
  localparam int BASIC_LEN = 3;

  localparam logic [2:0] KIND_FETCH = 3'd0;
  localparam logic [2:0] KIND_MRD   = 3'd1;
  localparam logic [2:0] KIND_MWR   = 3'd2;
  localparam logic [2:0] KIND_IORD  = 3'd3;
  localparam logic [2:0] KIND_IOWR  = 3'd4;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  function automatic logic kind_legal(input logic [2:0] k);
    return k <= KIND_IOWR;
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == KIND_MWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic [2:0] cycle_len(input logic [2:0] k);
    return (k == KIND_FETCH) ? 3'(FETCH_LEN) : 3'(BASIC_LEN);
  endfunction

  function automatic status_t status_of(input logic [2:0] k);
    status_t st;
    case (k)
      KIND_FETCH: st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      KIND_MRD:   st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      KIND_MWR:   st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      KIND_IORD:  st = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      KIND_IOWR:  st = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default:    st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
    endcase
    return st;
  endfunction

endpackage

// File: rtl/bus_seq_timer.sv
module bus_seq_timer
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] kind_in,
  output tstate_e    ts,
  output logic       last_t,
  output logic       done
);

  logic [2:0] len_q;

  assign last_t = (ts != TS_IDLE) && (3'(ts) == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts    <= TS_IDLE;
      len_q <= 3'd0;
      done  <= 1'b0;
    end else begin
      done <= last_t;
      if (ts == TS_IDLE) begin
        if (start) begin
          ts    <= TS_T1;
          len_q <= cycle_len(kind_in);
        end
      end else if (last_t) begin
        ts <= TS_IDLE;
      end else begin
        ts <= tstate_e'(3'(ts) + 3'd1);
      end
    end
  end

endmodule

// File: rtl/bus_seq_req_reg.sv
module bus_seq_req_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [2:0]        kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      kind_q  <= kind_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           ts,
  input  logic [2:0]        kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic              strobe_phase,
  output logic              sample_now,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rdata
);

  logic    active;
  logic    wr_kind;
  status_t st;

  assign active       = (ts != TS_IDLE);
  assign wr_kind      = kind_writes(kind_q);
  assign strobe_phase = (ts == TS_T2) || (ts == TS_T3);
  assign sample_now   = (ts == TS_T3) && !wr_kind;
  assign st           = active ? status_of(kind_q) : '0;

  always_comb begin
    ale     = (ts == TS_T1);
    io_m    = st.io_m;
    s1      = st.s1;
    s0      = st.s0;
    rd_n    = !(strobe_phase && !wr_kind);
    wr_n    = !(strobe_phase && wr_kind);
    addr_hi = active ? addr_q[ADDR_W-1:DATA_W] : '0;
    ad_oe   = 1'b0;
    ad_out  = '0;
    if (ts == TS_T1) begin
      ad_oe  = 1'b1;
      ad_out = addr_q[DATA_W-1:0];
    end else if (strobe_phase && wr_kind) begin
      ad_oe  = 1'b1;
      ad_out = wdata_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (sample_now) begin
      rdata <= ad_in;
    end
  end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              rd_n,
  output logic              wr_n,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in
);

  tstate_e           ts;
  logic              start;
  logic              last_t;
  logic              strobe_phase;
  logic              sample_now;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign busy  = (ts != TS_IDLE);
  assign start = req_valid && !busy && kind_legal(req_kind);

  bus_seq_timer u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .kind_in(req_kind),
    .ts     (ts),
    .last_t (last_t),
    .done   (done)
  );

  bus_seq_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .kind_in (req_kind),
    .addr_in (req_addr),
    .wdata_in(req_wdata),
    .kind_q  (kind_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts          (ts),
    .kind_q      (kind_q),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .ad_in       (ad_in),
    .strobe_phase(strobe_phase),
    .sample_now  (sample_now),
    .addr_hi     (addr_hi),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe),
    .ale         (ale),
    .io_m        (io_m),
    .s1          (s1),
    .s0          (s0),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .rdata       (rdata)
  );

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            ale,
  input logic            io_m,
  input logic            s1,
  input logic            s0,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic [HI_W-1:0] addr_hi
);

  // R1
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && ale));

  // R3
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(addr_hi));

  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable({io_m, s1, s0}));

  // R4
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ({io_m, s1, s0} == 3'b000));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R8
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind bus_seq_top bus_seq_chk #(.HI_W(HI_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .ale    (ale),
  .io_m   (io_m),
  .s1     (s1),
  .s0     (s0),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .ad_oe  (ad_oe),
  .addr_hi(addr_hi)
);

// File: tb/bus_seq_top_test.sv
`timescale 1ns/1ps
module bus_seq_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = 16'd0;
  logic [7:0]  req_wdata = 8'd0;
  logic [7:0]  ad_in = 8'h11;
  logic        busy, done, ale, io_m, s1, s0, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, addr_hi, ad_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_seq_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n),
    .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in)
  );

  // behavioural reference: T-state number, latched request, outputs
  int          m_t = 0;
  int          m_kind = 0;
  logic [15:0] m_addr = 16'd0;
  logic [7:0]  m_wd = 8'd0;
  logic        m_done = 1'b0;
  logic [7:0]  m_rdata = 8'd0;

  function automatic int ref_len(input int k);
    if (k == 0) return 4;
    return 3;
  endfunction

  function automatic bit ref_is_wr(input int k);
    return (k == 2) || (k == 4);
  endfunction

  function automatic logic [2:0] ref_status(input int t, input int k);
    logic [2:0] table_v [5] = '{3'b011, 3'b010, 3'b001, 3'b110, 3'b101};
    if (t == 0) return 3'b000;
    return table_v[k];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t <= 0; m_kind <= 0; m_addr <= 0; m_wd <= 0;
      m_done <= 1'b0; m_rdata <= 8'd0;
    end else begin
      m_done <= (m_t != 0) && (m_t == ref_len(m_kind));
      if (m_t == 3 && !ref_is_wr(m_kind)) m_rdata <= ad_in;
      if (m_t == 0) begin
        if (req_valid && req_kind <= 3'd4) begin
          m_t <= 1; m_kind <= int'(req_kind);
          m_addr <= req_addr; m_wd <= req_wdata;
        end
      end else if (m_t == ref_len(m_kind)) begin
        m_t <= 0;
      end else begin
        m_t <= m_t + 1;
      end
    end
  end

  always @(negedge clk) ad_in <= ad_in + 8'h37;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      bit mid;
      bit wrk;
      logic [7:0] e_hi;
      mid = (m_t == 2) || (m_t == 3);
      wrk = ref_is_wr(m_kind);
      e_hi = (m_t != 0) ? m_addr[15:8] : 8'd0;
      check(busy == (m_t != 0), "R2", "busy", 16'(busy), 16'(m_t != 0));
      check(ale == (m_t == 1), "R3", "ale", 16'(ale), 16'(m_t == 1));
      check(addr_hi == e_hi, "R3", "addr_hi", 16'(addr_hi), 16'(e_hi));
      if (m_t == 1)
        check(ad_oe && ad_out == m_addr[7:0], "R3", "ad_out addr",
              {7'd0, ad_oe, ad_out}, {8'd1, m_addr[7:0]});
      check({io_m, s1, s0} == ref_status(m_t, m_kind), "R4", "status",
            16'({io_m, s1, s0}), 16'(ref_status(m_t, m_kind)));
      check(rd_n == !(mid && !wrk) && wr_n == !(mid && wrk), "R5", "strobes",
            16'({rd_n, wr_n}), 16'({!(mid && !wrk), !(mid && wrk)}));
      if (mid && wrk)
        check(ad_oe && ad_out == m_wd, "R6", "write data",
              {7'd0, ad_oe, ad_out}, {8'd1, m_wd});
      else if (m_t >= 2)
        check(!ad_oe, "R6", "release", 16'(ad_oe), 16'd0);
      if (m_t == 4)
        check(rd_n && wr_n && !ad_oe, "R8", "T4 quiet",
              16'({rd_n, wr_n, ad_oe}), 16'b110);
      check(rdata == m_rdata, "R7", "rdata", 16'(rdata), 16'(m_rdata));
      check(done == m_done, "R8", "done", 16'(done), 16'(m_done));
    end
  end

  task automatic wait_idle();
    while (m_t != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 3'd7; req_addr = ~a; req_wdata = ~d;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    check(!busy && !done && !ale && !ad_oe && rd_n && wr_n &&
          {io_m, s1, s0} == 3'b000 && rdata == 8'd0, "R9", "reset state",
          {busy, done, ale, ad_oe, rd_n, wr_n, io_m, s1, s0, 7'd0},
          16'b0000_1100_0000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    // each kind (R2 R4 R5 R6 R7)
    send(3'd0, 16'h1234, 8'h00);
    send(3'd1, 16'hABCD, 8'h00);
    send(3'd2, 16'h00FF, 8'hC3);
    send(3'd3, 16'h4242, 8'h00);
    send(3'd4, 16'h8001, 8'h5A);
    send(3'd0, 16'hFFFF, 8'h00);
    send(3'd1, 16'h0000, 8'h00);
    // R1 requests while busy are ignored
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h3C3C; req_wdata = 8'h96;
    @(negedge clk);
    req_kind = 3'd1; req_addr = 16'hEEEE;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    // R1 illegal codes ignored
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h7777;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(!busy && !ale && rd_n && wr_n, "R1", "illegal code start",
            16'({busy, ale, rd_n, wr_n}), 16'b0011);
    end
    // R1 back-to-back: request held high through done clocks
    req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h2468;
    repeat (6) @(negedge clk);
    req_kind = 3'd4; req_addr = 16'h1357; req_wdata = 8'hE1;
    repeat (7) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule